// File: doc/BRIEF.md
# Semi-Parallel Multichannel Symmetric FIR Filter

This block filters several interleaved sample streams with one linear-phase FIR response. The clock runs K times faster than the composite sample rate, which is the channel count times the per-channel rate, so each multiplier stage is shared across K coefficients of every channel. The taps are split into K phases. In each cycle every stage handles one coefficient of the current phase. The partial sums of the K phases are folded together over K cycles to form one output sample.

The coefficient set is symmetric, so each stage first adds the two stored samples that share a coefficient and then multiplies the sum once. With an odd tap count, the centre sample is multiplied alone. The stage products pass down a cascade chain. The last stage sums three terms: its own product, the cascade input and its own previous result. This removes the need for a separate phase accumulator. The coefficients are computed at elaboration into small per-stage ROMs. The result is kept at full precision.

Samples enter one at a time with a channel tag. Each result leaves as a one-cycle pulse carrying the same tag.

Top module: `fir_semipar`

## Requirements
- R1: A sample accepted at clock edge t produces a one-cycle `out_valid` pulse registered at edge t+K, with `out_ch` equal to that sample's tag.
- R2: `out_data` is the signed sum over i = 0..NTAP-1 of h(i)·x_c[n-i], where x_c[n-i] is the sample of channel c received i samples earlier on that channel. The sum is kept at full precision in SW+CW+clog2(NTAP) bits.
- R3: The coefficients are h(j) = h(NTAP-1-j) = ((29·j + 7) mod 251) − 125 for 0 ≤ j < ceil(NTAP/2).
- R4: When NTAP is odd, the centre tap h((NTAP-1)/2) is applied to its sample exactly once, not twice.
- R5: Each channel keeps its own sample history. Samples of other channels never enter its sum.
- R6: A new sample may arrive every K cycles, including back-to-back samples on the same channel. A sample arriving in the cycle after the last phase of the previous one does not disturb that result.
- R7: `out_data` and `out_ch` hold their values between output pulses.
- R8: After reset, `out_valid` is 0, `out_data` is 0 and every channel's history is zero.
- R9: `out_valid` never pulses unless a sample was accepted exactly K edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe, at most once every K cycles |
| in_ch | input | CHW | Channel tag of the incoming sample |
| in_data | input | SW | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_ch | output | CHW | Channel tag of the result |
| out_data | output | AW | Signed full-precision filter output |

## Verification
The bench builds the filter with three channels, K = 4, eleven taps, 12-bit samples and 18-bit coefficients. The odd tap count places the centre tap inside the second stage. The six unique coefficients do not fill the eight stage-phase slots, so zero-padded slots are exercised too. The channel count is not a power of two, which tests tag handling beyond a full binary range. Samples spaced exactly K cycles apart keep the phase counter running without a gap between results. Impulses trace out the coefficient order, and extreme negative inputs push the sum toward the top of the accumulator width.

// File: rtl/fir_pkg.sv
package fir_pkg;

    // Unique half of the symmetric impulse response, index 0 .. ceil(NTAP/2)-1
    function automatic int coef_at(input int j);
        return ((j * 29 + 7) % 251) - 125;
    endfunction

endpackage

// File: rtl/fir_hist.sv
module fir_hist #(
    parameter int CH   = 4,
    parameter int NTAP = 11,
    parameter int SW   = 12,
    parameter int CHW  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [CHW-1:0]       wr_ch,
    input  logic [SW-1:0]        wr_data,
    input  logic [CHW-1:0]       rd_ch,
    output logic [NTAP*SW-1:0]   taps
);
    logic [SW-1:0] hist_q [CH][NTAP];
    logic [SW-1:0] hist_d [CH][NTAP];

    always_comb begin
        hist_d = hist_q;
        if (wr && int'(wr_ch) < CH) begin
            for (int i = NTAP - 1; i > 0; i--) begin
                hist_d[int'(wr_ch)][i] = hist_q[int'(wr_ch)][i-1];
            end
            hist_d[int'(wr_ch)][0] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < CH; c++) begin
                for (int i = 0; i < NTAP; i++) begin
                    hist_q[c][i] <= '0;
                end
            end
        end else begin
            hist_q <= hist_d;
        end
    end

    always_comb begin
        taps = '0;
        if (int'(rd_ch) < CH) begin
            for (int i = 0; i < NTAP; i++) begin
                taps[i*SW +: SW] = hist_q[int'(rd_ch)][i];
            end
        end
    end
endmodule

// File: rtl/fir_stage.sv
module fir_stage #(
    parameter int SW    = 12,
    parameter int CW    = 18,
    parameter int AW    = 34,
    parameter int K     = 4,
    parameter int NTAP  = 11,
    parameter int STAGE = 0,
    parameter int PHW   = 2
) (
    input  logic [PHW-1:0]          ph,
    input  logic [NTAP*SW-1:0]      taps,
    input  logic signed [AW-1:0]    cas_in,
    input  logic signed [AW-1:0]    fb,
    input  logic                    fb_en,
    output logic signed [AW-1:0]    sum
);
    localparam int NHALF = NTAP / 2;
    localparam int NUNIQ = (NTAP + 1) / 2;
    localparam bit ODD   = (NTAP % 2) == 1;
    localparam int NROM  = 1 << PHW;

    logic signed [CW-1:0] rom [NROM];

    for (genvar p = 0; p < NROM; p++) begin : g_rom
        localparam int J = STAGE * K + p;
        if (p < K && J < NUNIQ) begin : g_val
            assign rom[p] = CW'(fir_pkg::coef_at(J));
        end else begin : g_zero
            assign rom[p] = '0;
        end
    end

    logic signed [SW-1:0]    x_a, x_b;
    logic signed [SW:0]      pre;
    logic signed [SW+CW:0]   prod;
    logic signed [AW-1:0]    prod_ext;
    int                      jj;

    always_comb begin
        jj  = STAGE * K + int'(ph);
        x_a = '0;
        x_b = '0;
        if (jj < NHALF) begin
            x_a = taps[jj*SW +: SW];
            x_b = taps[(NTAP-1-jj)*SW +: SW];
        end else if (ODD && jj == NHALF) begin
            x_a = taps[jj*SW +: SW];
        end
        pre      = {x_a[SW-1], x_a} + {x_b[SW-1], x_b};
        prod     = pre * rom[ph];
        prod_ext = prod;
        sum      = cas_in + prod_ext + (fb_en ? fb : '0);
    end
endmodule

// File: rtl/fir_semipar.sv
module fir_semipar #(
    parameter int CH   = 4,
    parameter int K    = 4,
    parameter int NTAP = 11,
    parameter int SW   = 12,
    parameter int CW   = 18,
    localparam int CHW = (CH > 1) ? $clog2(CH) : 1,
    localparam int AW  = SW + CW + $clog2(NTAP)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [CHW-1:0]       in_ch,
    input  logic [SW-1:0]        in_data,
    output logic                 out_valid,
    output logic [CHW-1:0]       out_ch,
    output logic [AW-1:0]        out_data
);
    localparam int PHW   = (K > 1) ? $clog2(K) : 1;
    localparam int NUNIQ = (NTAP + 1) / 2;
    localparam int NSTG  = (NUNIQ + K - 1) / K;

    typedef struct packed {
        logic                  run;
        logic [PHW-1:0]        ph;
        logic [CHW-1:0]        ch;
        logic signed [AW-1:0]  acc;
        logic                  ov;
        logic [CHW-1:0]        och;
        logic signed [AW-1:0]  od;
    } state_t;

    state_t q, d;

    logic [NTAP*SW-1:0]   taps;
    logic signed [AW-1:0] cas [NSTG+1];

    fir_hist #(.CH(CH), .NTAP(NTAP), .SW(SW), .CHW(CHW)) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (in_valid),
        .wr_ch   (in_ch),
        .wr_data (in_data),
        .rd_ch   (q.ch),
        .taps    (taps)
    );

    assign cas[0] = '0;

    for (genvar s = 0; s < NSTG; s++) begin : g_stg
        if (s == NSTG - 1) begin : g_last
            fir_stage #(.SW(SW), .CW(CW), .AW(AW), .K(K), .NTAP(NTAP),
                        .STAGE(s), .PHW(PHW)) u_stage (
                .ph     (q.ph),
                .taps   (taps),
                .cas_in (cas[s]),
                .fb     (q.acc),
                .fb_en  (q.ph != '0),
                .sum    (cas[s+1])
            );
        end else begin : g_mid
            fir_stage #(.SW(SW), .CW(CW), .AW(AW), .K(K), .NTAP(NTAP),
                        .STAGE(s), .PHW(PHW)) u_stage (
                .ph     (q.ph),
                .taps   (taps),
                .cas_in (cas[s]),
                .fb     ('0),
                .fb_en  (1'b0),
                .sum    (cas[s+1])
            );
        end
    end

    always_comb begin
        d    = q;
        d.ov = 1'b0;
        if (q.run) begin
            d.acc = cas[NSTG];
            if (int'(q.ph) == K - 1) begin
                d.run = 1'b0;
                d.ph  = '0;
                d.ov  = 1'b1;
                d.och = q.ch;
                d.od  = cas[NSTG];
            end else begin
                d.ph = q.ph + 1'b1;
            end
        end
        if (in_valid) begin
            d.run = 1'b1;
            d.ph  = '0;
            d.ch  = in_ch;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid = q.ov;
    assign out_ch    = q.och;
    assign out_data  = q.od;
endmodule

// File: rtl/fir_semipar_chk.sv
module fir_semipar_chk #(
    parameter int K   = 4,
    parameter int CHW = 2,
    parameter int AW  = 34
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [CHW-1:0] in_ch,
    input logic           out_valid,
    input logic [CHW-1:0] out_ch,
    input logic [AW-1:0]  out_data
);
    localparam int CNW = $clog2(K + 1) + 1;

    logic           pend_q;
    logic [CNW-1:0] cnt_q;
    logic [CHW-1:0] pch_q;
    logic           due;

    assign due = pend_q && (int'(cnt_q) == K);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            pch_q  <= '0;
        end else if (in_valid) begin
            pend_q <= 1'b1;
            cnt_q  <= CNW'(1);
            pch_q  <= in_ch;
        end else if (pend_q) begin
            if (int'(cnt_q) == K) pend_q <= 1'b0;
            else                  cnt_q  <= cnt_q + 1'b1;
        end
    end

    AST_OUT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        due |=> (out_valid && out_ch == $past(pch_q)));                 // R1

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(due));                                       // R9

    AST_IN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (!pend_q || int'(cnt_q) == K));                     // R6

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_data) && $stable(out_ch)));          // R7
endmodule

bind fir_semipar fir_semipar_chk #(.K(K), .CHW(CHW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ch     (in_ch),
    .out_valid (out_valid),
    .out_ch    (out_ch),
    .out_data  (out_data)
);

// File: tb/fir_semipar_tb.sv
module fir_semipar_tb;
    localparam int CH   = 3;
    localparam int K    = 4;
    localparam int NTAP = 11;
    localparam int SW   = 12;
    localparam int CW   = 18;
    localparam int CHW  = 2;
    localparam int AW   = SW + CW + $clog2(NTAP);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [CHW-1:0] in_ch = '0;
    logic [SW-1:0]  in_data = '0;
    logic           out_valid;
    logic [CHW-1:0] out_ch;
    logic [AW-1:0]  out_data;

    always #10 clk = ~clk;

    fir_semipar #(.CH(CH), .K(K), .NTAP(NTAP), .SW(SW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
        .in_data(in_data), .out_valid(out_valid), .out_ch(out_ch),
        .out_data(out_data)
    );

    int     n_chk = 0;
    int     n_bad = 0;
    int     cyc   = 0;
    longint hx [CH][NTAP];
    int     q_ch[$];
    longint q_val[$];
    int     q_cyc[$];
    longint last_val = 0;
    int     last_ch  = 0;
    bit     done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint h_of(input int i);
        int j;
        j = (i < NTAP - 1 - i) ? i : NTAP - 1 - i;
        return longint'(((j * 29 + 7) % 251) - 125);
    endfunction

    task automatic clear_model();
        for (int c = 0; c < CH; c++)
            for (int i = 0; i < NTAP; i++) hx[c][i] = 0;
        q_ch.delete(); q_val.delete(); q_cyc.delete();
    endtask

    // driver: called at a falling edge; pushes the expected result
    task automatic send(input int ch, input int x, input int gap);
        longint y;
        in_valid = 1'b1;
        in_ch    = CHW'(ch);
        in_data  = SW'(x);
        for (int i = NTAP - 1; i > 0; i--) hx[ch][i] = hx[ch][i-1];
        hx[ch][0] = longint'(x);
        y = 0;
        for (int i = 0; i < NTAP; i++) y += h_of(i) * hx[ch][i];
        q_ch.push_back(ch);
        q_val.push_back(y);
        q_cyc.push_back(cyc + 1 + K);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (K - 1 + gap) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_chk++;
            if (q_ch.size() == 0) begin
                n_bad++;
                $display("FAIL R9 unexpected output: actual ch=%0d data=%0d expected no output",
                         out_ch, $signed(out_data));
            end else begin
                int     ec, ecyc;
                longint ev;
                ec = q_ch.pop_front(); ev = q_val.pop_front(); ecyc = q_cyc.pop_front();
                if (int'(out_ch) != ec || longint'($signed(out_data)) != ev || cyc != ecyc) begin
                    n_bad++;
                    $display("FAIL R1/R2 output: actual ch=%0d data=%0d cyc=%0d expected ch=%0d data=%0d cyc=%0d",
                             out_ch, $signed(out_data), cyc, ec, ev, ecyc);
                end
                last_val = ev;
                last_ch  = ec;
            end
        end
    end

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int seed;
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        check(out_valid == 1'b0, "R8 out_valid after reset", longint'(out_valid), 0);
        check(out_data == '0, "R8 out_data after reset", longint'($signed(out_data)), 0);

        // R3/R4: impulse on channel 0 then zeros traces every coefficient incl. centre
        send(0, 1, 0);
        for (int i = 1; i < NTAP + 1; i++) send(0, 0, 0);

        // R5: impulse on channel 2 with channel 1 busy, histories kept apart
        send(2, 100, 0);
        for (int i = 0; i < NTAP; i++) begin
            send(1, i * 37 - 200, 0);
            send(2, 0, 0);
        end

        // R7: idle gap, data must hold
        repeat (3 * K) @(negedge clk);
        check(out_data == AW'(last_val), "R7 out_data held", longint'($signed(out_data)), last_val);
        check(int'(out_ch) == last_ch, "R7 out_ch held", longint'(out_ch), longint'(last_ch));

        // R2: extreme values, full precision
        for (int i = 0; i < NTAP + 2; i++) send(1, -2048, 0);
        for (int i = 0; i < NTAP + 2; i++) send(0, (i % 2) ? 2047 : -2048, 0);

        // R6/R2: pseudo-random interleave with occasional gaps
        seed = 12345;
        for (int i = 0; i < 150; i++) begin
            int x, c;
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            c = (seed >> 16) % CH;
            x = ((seed >> 4) % 4096) - 2048;
            send(c, x, (i % 17 == 0) ? 2 : 0);
        end

        // R9: long idle, no pulses expected
        repeat (5 * K) @(negedge clk);
        check(q_ch.size() == 0, "R1 results outstanding", longint'(q_ch.size()), 0);

        // R8: reset clears histories
        do_reset();
        check(out_valid == 1'b0, "R8 out_valid after second reset", longint'(out_valid), 0);
        send(1, 5, 0);
        send(1, 0, 0);
        repeat (2 * K) @(negedge clk);
        check(q_ch.size() == 0, "R8 results outstanding", longint'(q_ch.size()), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule